// File: doc/BRIEF.md
# Data-Strobe Delay Window Calibration Engine

This engine finds the range of data-strobe delay settings at which a memory interface reads back correctly, then leaves the delay at a point inside that range. After a start pulse it walks a delay index upward from zero. Each index drives the delay control output in Gray code, so consecutive settings differ by a single bit. After a fixed settling time it runs a write-and-readback test over six memory words. Alternate words sit in the second memory bank.

The first index that passes becomes the low edge of the window. The engine then moves to a second address region and keeps stepping from that index until a test fails or the index range is used up, which gives the high edge. The final setting is placed two thirds of the way from the low edge to the high edge. If no index passes, a fixed default code is driven and a fail flag is raised. A one-cycle done pulse marks the end of a run.

Memory traffic uses a valid/ready request channel. A request holds its address, data and direction unchanged until `req_ready` accepts it. Only one read is outstanding at a time. Read data returns on a response channel that has no back-pressure: the engine takes `rsp_rdata` in any cycle that `rsp_valid` is high.

Top module: `dqs_cal_engine`

## Requirements
- R1: After reset, `done`, `cal_fail`, `req_valid`, `dly_code`, `lo_idx`, `hi_idx` and `final_code` are all 0.
- R2: During a run the index steps upward from 0 and `dly_code` equals index XOR (index >> 1). Successive tests therefore see codes that differ in at most one bit. At least SETTLE_CYC clocks pass after `dly_code` changes before the next request is raised.
- R3: Each test makes 18 requests in this order: six writes of 0, then six writes of the patterns 0x12345678, 0x81234567, 0x78123456, 0x67812345, 0x56781234 and 0x45678123 (slot k gets the first pattern rotated right by 4·k bits), then six reads. Slot k uses address region + k·0x100, plus BANK1_OFF (default 0x0100_0000) when k is odd. A test passes only if every read returns its slot's pattern.
- R4: The low-edge search uses region 0x4000. The high-edge search uses region 0x8000.
- R5: `lo_idx` is the first index whose test passes in the low-edge search. The search covers indices 0 to 0xFE.
- R6: The high-edge search starts again at `lo_idx`. `hi_idx` is the first index whose test fails there. If index 0xFE still passes, `hi_idx` is 0xFF.
- R7: On success, with final = lo + (2·(hi − lo)) / 3 (integer division), `final_code` and `dly_code` both become final XOR (final >> 1), and `cal_fail` is 0.
- R8: If no index passes the low-edge search, `cal_fail` is 1, `dly_code` and `final_code` are 0x59, and `lo_idx` and `hi_idx` are 0.
- R9: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_write`, `req_addr` and `req_wdata` stay unchanged. No new request is raised while a read response is pending.
- R10: `done` is high for exactly one cycle at the end of a run. A `start` pulse received while a run is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that begins a calibration run when idle |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory request accepted |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 32 | Word address of the request |
| req_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | Read data valid (always taken) |
| rsp_rdata | input | 32 | Read data |
| dly_code | output | 8 | Gray-coded delay control |
| lo_idx | output | 8 | Low edge of the passing window |
| hi_idx | output | 8 | High edge (first failing index) |
| final_code | output | 8 | Gray code of the chosen setting |
| cal_fail | output | 1 | No passing setting was found |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Assertions check every cycle for the following:
- a stalled request stays unchanged;
- `dly_code` moves by no more than one bit inside a run;
- `done` is a single-cycle pulse;
- a failed run leaves the default code;
- a successful run reports a high edge at or above the low edge.

The bench scenarios cover everything that depends on memory contents. These are:
- where the window edges fall;
- the two-thirds placement and its Gray encoding;
- the exact order, addresses and data of the 18 test requests;
- which address region each search uses;
- the settling gap;
- the fallback when no setting passes;
- whether a start pulse in mid-run disturbs the result.

// File: rtl/dqs_cal_pkg.sv
package dqs_cal_pkg;
  localparam int WORD_W = 32;
  localparam int SLOTS  = 6;

  typedef enum logic [2:0] {C_IDLE, C_SETTLE, C_RUN, C_FIN} ctrl_st_t;
  typedef enum logic [1:0] {Q_IDLE, Q_REQ, Q_WAIT} seq_st_t;

  // pattern for slot k: seed rotated right by 4*k bits
  function automatic logic [WORD_W-1:0] slot_pattern(input logic [WORD_W-1:0] seed,
                                                     input int unsigned k);
    int unsigned sh;
    sh = 4 * k;
    if (sh == 0) return seed;
    return (seed >> sh) | (seed << (WORD_W - sh));
  endfunction
endpackage

// File: rtl/dqs_pattern_test.sv
module dqs_pattern_test
  import dqs_cal_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] STRIDE   = 'h100,
  parameter logic [ADDR_W-1:0] BANK_OFF = 'h0100_0000,
  parameter logic [WORD_W-1:0] SEED     = 32'h1234_5678
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] base,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [WORD_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] rsp_rdata,
  output logic              test_done,
  output logic              test_pass
);
  localparam int OPS  = 3 * SLOTS;
  localparam int OP_W = $clog2(OPS);

  seq_st_t          st;
  logic [OP_W-1:0]  op;
  logic             mism;
  int unsigned      slot;
  logic [WORD_W-1:0] pat;

  always_comb begin
    if (int'(op) < SLOTS)          slot = int'(op);
    else if (int'(op) < 2 * SLOTS) slot = int'(op) - SLOTS;
    else                           slot = int'(op) - 2 * SLOTS;
    pat       = slot_pattern(SEED, slot);
    req_valid = (st == Q_REQ);
    req_write = (int'(op) < 2 * SLOTS);
    req_wdata = (int'(op) < SLOTS) ? '0 : pat;
    req_addr  = base + ADDR_W'(slot) * STRIDE + ((slot % 2 == 1) ? BANK_OFF : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= Q_IDLE;
      op        <= '0;
      mism      <= 1'b0;
      test_done <= 1'b0;
      test_pass <= 1'b0;
    end else begin
      test_done <= 1'b0;
      case (st)
        Q_IDLE: if (go) begin
          op   <= '0;
          mism <= 1'b0;
          st   <= Q_REQ;
        end
        Q_REQ: if (req_ready) begin
          if (req_write) op <= op + 1'b1;
          else           st <= Q_WAIT;
        end
        Q_WAIT: if (rsp_valid) begin
          if (int'(op) == OPS - 1) begin
            test_done <= 1'b1;
            test_pass <= !(mism || (rsp_rdata != pat));
            st        <= Q_IDLE;
          end else begin
            mism <= mism || (rsp_rdata != pat);
            op   <= op + 1'b1;
            st   <= Q_REQ;
          end
        end
        default: st <= Q_IDLE;
      endcase
    end
  end

  // R9: a stalled request is held unchanged
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
                                   $stable(req_wdata) && $stable(req_write)));
  // R9: no request while a read response is pending
  assert_one_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> !req_valid);
endmodule

// File: rtl/dqs_window_pick.sv
module dqs_window_pick #(
  parameter int IDX_W = 8
) (
  input  logic [IDX_W-1:0] lo,
  input  logic [IDX_W-1:0] hi,
  output logic [IDX_W-1:0] pick
);
  localparam int EXT_W = IDX_W + 2;
  logic [EXT_W-1:0] span2;
  always_comb begin
    span2 = (EXT_W'(hi) - EXT_W'(lo)) << 1;
    pick  = lo + IDX_W'(span2 / EXT_W'(3));
  end
endmodule

// File: rtl/dqs_sweep_ctrl.sv
module dqs_sweep_ctrl
  import dqs_cal_pkg::*;
#(
  parameter int               IDX_W     = 8,
  parameter int               SETTLE_CYC = 4,
  parameter logic [IDX_W-1:0] DEF_CODE  = 8'h59
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             test_done,
  input  logic             test_pass,
  input  logic [IDX_W-1:0] pick,
  output logic             test_go,
  output logic             high_ph,
  output logic [IDX_W-1:0] dly_code,
  output logic [IDX_W-1:0] lo_idx,
  output logic [IDX_W-1:0] hi_idx,
  output logic [IDX_W-1:0] final_code,
  output logic             cal_fail,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST  = IDX_W'((1 << IDX_W) - 2);
  localparam int               CNT_W = $clog2(SETTLE_CYC + 1);

  ctrl_st_t         st;
  logic [IDX_W-1:0] idx, idx_nx;
  logic [CNT_W-1:0] cnt;
  logic             miss;

  assign idx_nx = idx + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= C_IDLE; idx <= '0; cnt <= '0; miss <= 1'b0; high_ph <= 1'b0;
      test_go <= 1'b0; dly_code <= '0; lo_idx <= '0; hi_idx <= '0;
      final_code <= '0; cal_fail <= 1'b0; done <= 1'b0;
    end else begin
      done    <= 1'b0;
      test_go <= 1'b0;
      case (st)
        C_IDLE: if (start) begin
          idx <= '0; dly_code <= '0; high_ph <= 1'b0; miss <= 1'b0;
          cnt <= '0; st <= C_SETTLE;
        end
        C_SETTLE: if (int'(cnt) == SETTLE_CYC - 1) begin
          test_go <= 1'b1;
          st      <= C_RUN;
        end else cnt <= cnt + 1'b1;
        C_RUN: if (test_done) begin
          cnt <= '0;
          if (!high_ph) begin
            if (test_pass) begin
              lo_idx <= idx; high_ph <= 1'b1; st <= C_SETTLE;
            end else if (idx == LAST) begin
              miss <= 1'b1; st <= C_FIN;
            end else begin
              idx <= idx_nx; dly_code <= idx_nx ^ (idx_nx >> 1); st <= C_SETTLE;
            end
          end else begin
            if (!test_pass) begin
              hi_idx <= idx; st <= C_FIN;
            end else if (idx == LAST) begin
              hi_idx <= idx_nx; st <= C_FIN;
            end else begin
              idx <= idx_nx; dly_code <= idx_nx ^ (idx_nx >> 1); st <= C_SETTLE;
            end
          end
        end
        C_FIN: begin
          done <= 1'b1;
          st   <= C_IDLE;
          if (miss) begin
            cal_fail <= 1'b1; lo_idx <= '0; hi_idx <= '0;
            dly_code <= DEF_CODE; final_code <= DEF_CODE;
          end else begin
            cal_fail   <= 1'b0;
            dly_code   <= pick ^ (pick >> 1);
            final_code <= pick ^ (pick >> 1);
          end
        end
        default: st <= C_IDLE;
      endcase
    end
  end

  // R2: inside a run the delay code changes by at most one bit per step
  assert_gray_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st != C_IDLE && $past(st) != C_IDLE) |-> ($countones(dly_code ^ $past(dly_code)) <= 1));
  // R10: done is a single-cycle pulse
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: a failed run leaves the default code on the delay output
  assert_fail_default_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cal_fail) |-> (dly_code == DEF_CODE && final_code == DEF_CODE));
  // R6: a successful run reports an ordered window
  assert_window_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cal_fail) |-> (hi_idx >= lo_idx));
endmodule

// File: rtl/dqs_cal_engine.sv
module dqs_cal_engine
  import dqs_cal_pkg::*;
#(
  parameter int                IDX_W      = 8,
  parameter int                ADDR_W     = 32,
  parameter int                SETTLE_CYC = 4,
  parameter logic [ADDR_W-1:0] LO_REGION  = 'h4000,
  parameter logic [ADDR_W-1:0] HI_REGION  = 'h8000,
  parameter logic [ADDR_W-1:0] BANK1_OFF  = 'h0100_0000,
  parameter logic [IDX_W-1:0]  DEF_CODE   = 8'h59
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [WORD_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] rsp_rdata,
  output logic [IDX_W-1:0]  dly_code,
  output logic [IDX_W-1:0]  lo_idx,
  output logic [IDX_W-1:0]  hi_idx,
  output logic [IDX_W-1:0]  final_code,
  output logic              cal_fail,
  output logic              done
);
  logic             t_go, t_done, t_pass, high_ph;
  logic [IDX_W-1:0] pick;

  dqs_sweep_ctrl #(.IDX_W(IDX_W), .SETTLE_CYC(SETTLE_CYC), .DEF_CODE(DEF_CODE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .test_done(t_done), .test_pass(t_pass),
    .pick(pick), .test_go(t_go), .high_ph(high_ph), .dly_code(dly_code),
    .lo_idx(lo_idx), .hi_idx(hi_idx), .final_code(final_code),
    .cal_fail(cal_fail), .done(done));

  dqs_window_pick #(.IDX_W(IDX_W)) u_pick (.lo(lo_idx), .hi(hi_idx), .pick(pick));

  dqs_pattern_test #(.ADDR_W(ADDR_W), .BANK_OFF(BANK1_OFF)) u_test (
    .clk(clk), .rst_n(rst_n), .go(t_go), .base(high_ph ? HI_REGION : LO_REGION),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .test_done(t_done), .test_pass(t_pass));
endmodule

// File: tb/sim_dqs_cal_engine.sv
module sim_dqs_cal_engine;
  localparam int SETTLE = 4;
  localparam logic [31:0] OFF = 32'h0100_0000;

  logic clk = 0, rst_n = 0, start = 0;
  logic req_valid, req_ready = 0, req_write, rsp_valid = 0, cal_fail, done;
  logic [31:0] req_addr, req_wdata, rsp_rdata = 0;
  logic [7:0] dly_code, lo_idx, hi_idx, final_code;

  always #2 clk = ~clk;

  dqs_cal_engine u0 (.*);

  int tests = 0, fails = 0, cyc = 0;
  int lw_lo, lw_hi, hw_lo, hw_hi;
  logic [31:0] mem [logic [31:0]];
  bit cap_en = 0;
  int cap_n = 0, hi_seen = 0, gray_viol = 0, settle_viol = 0, since = 0, rdy_cnt = 0;
  logic [31:0] cap_addr [18];
  logic [31:0] cap_data [18];
  logic        cap_wr [18];
  logic [7:0]  prev_code = 0, last_req_code = 0;
  logic [31:0] pats [6] = '{32'h12345678, 32'h81234567, 32'h78123456,
                            32'h67812345, 32'h56781234, 32'h45678123};

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic int ungray(input logic [7:0] g);
    logic [7:0] b;
    b[7] = g[7];
    for (int i = 6; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return int'(b);
  endfunction

  function automatic bit in_win(input logic [31:0] a);
    int i;
    i = ungray(dly_code);
    if (a[15:12] == 4'h4) return (i >= lw_lo && i <= lw_hi);
    return (i >= hw_lo && i <= hw_hi);
  endfunction

  // memory model
  always @(posedge clk) begin
    rsp_valid <= 1'b0;
    if (req_valid && req_ready) begin
      if (cap_en && cap_n < 18) begin
        cap_addr[cap_n] = req_addr; cap_data[cap_n] = req_wdata;
        cap_wr[cap_n] = req_write; cap_n++;
      end
      if (req_addr[15:12] == 4'h8) hi_seen++;
      if (req_write) mem[req_addr] = req_wdata;
      else begin
        rsp_valid <= 1'b1;
        rsp_rdata <= (mem.exists(req_addr) ? mem[req_addr] : 32'h0) ^ (in_win(req_addr) ? 32'h0 : 32'h1);
      end
    end
  end

  // ready pattern and monitors
  always @(negedge clk) begin
    rdy_cnt++;
    req_ready = (rdy_cnt % 3) != 2;
    if (dly_code != prev_code) since = 0; else since++;
    prev_code = dly_code;
    if (req_valid) begin
      if (since < SETTLE) settle_viol++;
      if ($countones(dly_code ^ last_req_code) > 1) gray_viol++;
      last_req_code = dly_code;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 199000) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=<199000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic expect_cal(output int lo, output int hi, output int fin, output bit f);
    lo = -1;
    for (int i = 0; i <= 254; i++) if (lo < 0 && i >= lw_lo && i <= lw_hi) lo = i;
    f = (lo < 0);
    if (f) begin lo = 0; hi = 0; fin = 'h59; return; end
    hi = 255;
    for (int i = lo; i <= 254; i++) if (hi == 255 && !(i >= hw_lo && i <= hw_hi)) hi = i;
    fin = lo + (2 * (hi - lo)) / 3;
  endtask

  task automatic run_cal(input string nm, input bit poke);
    int n, elo, ehi, efin;
    bit ef;
    logic [7:0] ecode;
    gray_viol = 0; settle_viol = 0; hi_seen = 0; last_req_code = 0; n = 0;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    while (!done && n < 60000) begin
      @(negedge clk); n++;
      if (poke && n == 300) start = 1;
      if (poke && n == 301) start = 0;
    end
    expect_cal(elo, ehi, efin, ef);
    ecode = ef ? 8'h59 : 8'(efin ^ (efin >> 1));
    chk(done == 1, {nm, " R10 done seen"}, 32'(done), 1);
    chk(cal_fail == ef, {nm, " R8 cal_fail"}, 32'(cal_fail), 32'(ef));
    chk(lo_idx == 8'(elo), {nm, " R5 lo_idx"}, 32'(lo_idx), elo);
    chk(hi_idx == 8'(ehi), {nm, " R6 hi_idx"}, 32'(hi_idx), ehi);
    chk(final_code == ecode, {nm, " R7 final_code"}, 32'(final_code), 32'(ecode));
    chk(dly_code == ecode, {nm, " R7 dly_code"}, 32'(dly_code), 32'(ecode));
    chk(gray_viol == 0, {nm, " R2 gray steps"}, gray_viol, 0);
    chk(settle_viol == 0, {nm, " R2 settle gap"}, settle_viol, 0);
    @(negedge clk);
    chk(done == 0, {nm, " R10 done one cycle"}, 32'(done), 0);
  endtask

  task automatic t_reset;
    chk(done == 0 && cal_fail == 0 && req_valid == 0, "R1 reset flags",
        {29'b0, done, cal_fail, req_valid}, 0);
    chk(dly_code == 0 && lo_idx == 0 && hi_idx == 0 && final_code == 0, "R1 reset values",
        {dly_code, lo_idx, hi_idx, final_code}, 0);
  endtask

  task automatic t_mid_window;
    logic [31:0] ea, ed;
    lw_lo = 40; lw_hi = 100; hw_lo = 40; hw_hi = 100;
    cap_n = 0; cap_en = 1;
    run_cal("mid", 1'b1);   // R10: extra start mid-run must not disturb
    cap_en = 0;
    for (int k = 0; k < 18; k++) begin
      int s;
      s  = k % 6;
      ea = 32'h4000 + 32'(s) * 32'h100 + ((s % 2 == 1) ? OFF : 32'h0);
      ed = (k < 6) ? 32'h0 : pats[s];
      chk(cap_addr[k] == ea, "R3 address order", cap_addr[k], ea);
      chk(cap_wr[k] == (k < 12), "R3 direction", 32'(cap_wr[k]), 32'(k < 12));
      if (k < 12) chk(cap_data[k] == ed, "R3 write data", cap_data[k], ed);
    end
    chk(hi_seen > 0, "R4 high region used", hi_seen, 1);
  endtask

  task automatic t_no_window;
    lw_lo = 300; lw_hi = 0; hw_lo = 300; hw_hi = 0;
    run_cal("none", 1'b0);
    chk(hi_seen == 0, "R4 no high region on miss", hi_seen, 0);
  endtask

  task automatic t_top_window;
    lw_lo = 200; lw_hi = 255; hw_lo = 200; hw_hi = 255;
    run_cal("top", 1'b0);
  endtask

  task automatic t_split_regions;
    lw_lo = 10; lw_hi = 20; hw_lo = 10; hw_hi = 12;   // R4: regions judged separately
    run_cal("split", 1'b0);
  endtask

  task automatic t_zero_window;
    lw_lo = 0; lw_hi = 0; hw_lo = 0; hw_hi = 0;
    run_cal("zero", 1'b0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_mid_window();
    t_no_window();
    t_top_window();
    t_split_regions();
    t_zero_window();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule